// File: doc/BRIEF.md
# Abacus-Coded Thermometric Adder

This is a purely combinational binary adder of width N, where N is a multiple of four. It has no ripple-sum binary core. Each operand is cut into 2-bit digits. Every digit becomes a 3-bit bead word in thermometer form, so the values 0, 1, 2 and 3 are carried as 000, 001, 011 and 111.

For each digit position, the bead word of operand `a` acts as a selector. It shifts the bead word of operand `b` up into a 6-bit thermometer sum. A small converter then folds that sum and the digit's carry-in into two binary sum bits and a carry-out. The carry-out is read straight off two thermometer positions.

Two digits form a 4-bit nibble unit. Each nibble exports a group generate and a group propagate. One level of lookahead logic computes the carry into every nibble in parallel from `cin`.

Top module: `abacus_adder`

## Requirements
- R1: For every input, {cout, sum} equals a + b + cin taken as an (N+1)-bit unsigned value.
- R2: A 2-bit digit of value v becomes the bead word {v==3, v>=2, v>=1}. That gives 000, 001, 011 and 111 for 0 to 3. Adding any digit value to zero returns it unchanged.
- R3: The 6-bit thermometer sum of a digit pair has its ones packed from bit 0 upward. Its number of ones equals the sum of the two digit values, which ranges from 0 to 6.
- R4: The two sum bits of each digit equal (thermometer count + digit carry-in) mod 4. The digit carry-out is bit 3 of the thermometer sum, or bit 2 when the carry-in is set.
- R5: For N=8, 9 + 13 with cin=0 gives sum 22 and cout 0. For N=4, the same operands give sum 6 and cout 1.
- R6: Inside a nibble, the low digit's carry feeds the high digit. The carry into each nibble matches the recurrence c(j+1) = G(j) + P(j)·c(j), with G and P the nibble's group generate and propagate. An all-ones operand plus cin=1 ripples a carry through every nibble.
- R7: cin enters at bit 0. Zero plus zero with cin=1 gives sum 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Sum bits |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
The assertions run on every evaluation of the logic. They check the bead encoding of each digit, the packed shape and ones-count of every thermometer sum, the per-digit sum bits and carry, agreement between each nibble carry and the carry leaving the nibble below, and the full arithmetic result.

Only the bench scenarios can show that whole input spaces are covered. The bench runs every input pattern at widths 4 and 8. At width 32 it runs wide carry chains through all nibbles and the named example sums, which the per-evaluation checks never force.

// File: rtl/abacus_adder.sv
module abacus_adder #(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  localparam int DIG = N / 2;
  localparam int NIB = N / 4;

  logic [3*DIG-1:0] xb, yb;
  logic [6*DIG-1:0] kv;
  logic [DIG-1:0]   dci, dco;
  logic [NIB-1:0]   gg, gp;
  logic [NIB:0]     nc;

  function automatic logic la_carry(input int j, input logic [NIB-1:0] g,
                                    input logic [NIB-1:0] p, input logic ci);
    logic c, pr;
    c  = 1'b0;
    for (int k = 0; k < j; k++) begin
      pr = g[k];
      for (int m = k + 1; m < j; m++) pr = pr & p[m];
      c = c | pr;
    end
    pr = ci;
    for (int m = 0; m < j; m++) pr = pr & p[m];
    return c | pr;
  endfunction

  for (genvar d = 0; d < DIG; d++) begin : g_dig
    logic [1:0] xd, yd;
    logic [2:0] x, y;
    logic [5:0] k;
    logic       c, t2, t4, t6;
    assign xd = a[2*d +: 2];
    assign yd = b[2*d +: 2];
    assign xb[3*d +: 3] = {xd[1] & xd[0], xd[1], xd[1] | xd[0]};
    assign yb[3*d +: 3] = {yd[1] & yd[0], yd[1], yd[1] | yd[0]};
    assign x = xb[3*d +: 3];
    assign y = yb[3*d +: 3];
    assign k = x[2] ? {y, 3'b111} :
               x[1] ? {1'b0, y, 2'b11} :
               x[0] ? {2'b00, y, 1'b1} : {3'b000, y};
    assign kv[6*d +: 6] = k;
    assign c  = dci[d];
    assign t2 = k[1] | (k[0] & c);
    assign t4 = k[3] | (k[2] & c);
    assign t6 = k[5] | (k[4] & c);
    assign sum[2*d]     = (^k) ^ c;
    assign sum[2*d + 1] = (t2 & ~t4) | t6;
    assign dco[d] = t4;
  end

  for (genvar j = 0; j < NIB; j++) begin : g_nib
    logic gl, pl, gh, ph;
    assign gl = kv[12*j + 3];
    assign pl = kv[12*j + 2];
    assign gh = kv[12*j + 9];
    assign ph = kv[12*j + 8];
    assign dci[2*j]     = nc[j];
    assign dci[2*j + 1] = gl | (pl & nc[j]);
    assign gg[j] = gh | (ph & gl);
    assign gp[j] = ph & pl;
    assign nc[j + 1] = la_carry(j + 1, gg, gp, cin);
  end

  assign nc[0] = cin;
  assign cout  = nc[NIB];
endmodule

// File: rtl/abacus_adder_chk.sv
module abacus_adder_chk #(
  parameter int N = 8
) (
  input logic [N-1:0]       a,
  input logic [N-1:0]       b,
  input logic               cin,
  input logic [N-1:0]       sum,
  input logic               cout,
  input logic [3*N/2-1:0]   xb,
  input logic [3*N/2-1:0]   yb,
  input logic [3*N-1:0]     kv,
  input logic [N/2-1:0]     dci,
  input logic [N/2-1:0]     dco,
  input logic [N/4:0]       nc
);
  localparam int DIG = N / 2;
  localparam int NIB = N / 4;

  always_comb begin
    p_total_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin}))
      else $error("R1 total mismatch");
  end

  for (genvar d = 0; d < DIG; d++) begin : g_d
    logic [1:0] va, vb;
    logic [5:0] k;
    logic [2:0] tot;
    assign va  = a[2*d +: 2];
    assign vb  = b[2*d +: 2];
    assign k   = kv[6*d +: 6];
    assign tot = 3'(va) + 3'(vb) + 3'(dci[d]);
    always_comb begin
      p_bead_r2: assert (xb[3*d +: 3] == {va == 2'd3, va >= 2'd2, va != 2'd0} &&
                         yb[3*d +: 3] == {vb == 2'd3, vb >= 2'd2, vb != 2'd0})
        else $error("R2 bead code wrong");
      p_therm_r3: assert ((((k + 6'd1) & k) == 6'd0) &&
                          ($countones(k) == int'(va) + int'(vb)))
        else $error("R3 thermometer sum wrong");
      p_digit_r4: assert (sum[2*d +: 2] == tot[1:0] && dco[d] == (tot >= 3'd4))
        else $error("R4 digit result wrong");
    end
  end

  for (genvar j = 0; j < NIB; j++) begin : g_n
    always_comb begin
      p_lookahead_r6: assert (nc[j + 1] == dco[2*j + 1] && dci[2*j + 1] == dco[2*j])
        else $error("R6 nibble carry mismatch");
    end
  end
endmodule

bind abacus_adder abacus_adder_chk #(.N(N)) i_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .xb(xb), .yb(yb), .kv(kv), .dci(dci), .dco(dco), .nc(nc)
);

// File: tb/test_abacus_adder.sv
module test_abacus_adder;
  localparam int CLK_PERIOD = 8;
  localparam int NV = 10;
  // {a, b, cin, expected {cout,sum}} for the 32-bit instance
  localparam logic [97:0] VEC [NV] = '{
    {32'h00000000, 32'h00000000, 1'b0, 33'h000000000},
    {32'h00000009, 32'h0000000d, 1'b0, 33'h000000016},
    {32'hffffffff, 32'h00000000, 1'b1, 33'h100000000},
    {32'hffffffff, 32'hffffffff, 1'b1, 33'h1ffffffff},
    {32'h33333333, 32'h11111111, 1'b0, 33'h044444444},
    {32'h33333333, 32'h11111111, 1'b1, 33'h044444445},
    {32'h88888888, 32'h88888888, 1'b0, 33'h111111110},
    {32'h0000000f, 32'h00000001, 1'b0, 33'h000000010},
    {32'h7fffffff, 32'h00000001, 1'b0, 33'h080000000},
    {32'h00000000, 32'h00000000, 1'b1, 33'h000000001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  logic [3:0]  a4, b4, s4;   logic c4, co4;
  logic [7:0]  a8, b8, s8;   logic c8, co8;
  logic [31:0] a32, b32, s32; logic c32, co32;

  always #(CLK_PERIOD / 2) clk = ~clk;

  abacus_adder #(.N(4))  i_abacus_adder_4  (.a(a4),  .b(b4),  .cin(c4),  .sum(s4),  .cout(co4));
  abacus_adder #(.N(8))  i_abacus_adder    (.a(a8),  .b(b8),  .cin(c8),  .sum(s8),  .cout(co8));
  abacus_adder #(.N(32)) i_abacus_adder_32 (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run32(input string req, input logic [31:0] x, input logic [31:0] y,
                       input logic ci, input logic [32:0] exp);
    a32 = x; b32 = y; c32 = ci;
    #2;
    check(req, {co32, s32}, exp);
  endtask

  initial begin
    a4 = '0; b4 = '0; c4 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    #1;
    #(2 * CLK_PERIOD);
    check("R1 reset-state 8", {24'd0, co8, s8}, 33'd0);
    check("R1 reset-state 32", {co32, s32}, 33'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run32("R1 table", VEC[i][97:66], VEC[i][65:34], VEC[i][33], VEC[i][32:0]);

    run32("R5 9+13 N32", 32'd9, 32'd13, 1'b0, 33'd22);
    run32("R6 carry through all nibbles", 32'hffffffff, 32'h0, 1'b1, 33'h100000000);
    run32("R6 generate at nibble 0 propagated", 32'h0fffffff, 32'h00000001, 1'b0, 33'h010000000);
    run32("R7 cin alone", 32'h0, 32'h0, 1'b1, 33'd1);

    a4 = 4'd9; b4 = 4'd13; c4 = 1'b0; #2;
    check("R5 9+13 N4", {28'd0, co4, s4}, 33'h16);
    a8 = 8'd9; b8 = 8'd13; c8 = 1'b0; #2;
    check("R5 9+13 N8", {24'd0, co8, s8}, 33'd22);

    for (int v = 0; v < 4; v++) begin
      a4 = 4'(v); b4 = 4'd0; c4 = 1'b0; #2;
      check("R2 digit plus zero", {28'd0, co4, s4}, 33'(v));
    end
    for (int v = 0; v < 4; v++) begin
      a4 = 4'(v); b4 = 4'd3; c4 = 1'b0; #2;
      check("R3 digit pair sum", {28'd0, co4, s4}, 33'(v + 3));
    end
    a4 = 4'd3; b4 = 4'd0; c4 = 1'b1; #2;
    check("R4 count 3 with carry-in", {28'd0, co4, s4}, 33'd4);
    a4 = 4'd3; b4 = 4'd3; c4 = 1'b1; #2;
    check("R4 count 6 with carry-in", {28'd0, co4, s4}, 33'd7);

    for (int i = 0; i < 512; i++) begin
      {a4, b4, c4} = 9'(i); #2;
      check("R1 exhaustive N4", {28'd0, co4, s4}, 33'(a4) + 33'(b4) + 33'(c4));
    end
    for (int i = 0; i < (1 << 17); i++) begin
      {a8, b8, c8} = 17'(i); #2;
      check("R1 exhaustive N8", {24'd0, co8, s8}, 33'(a8) + 33'(b8) + 33'(c8));
    end

    begin
      logic [31:0] st;
      st = 32'h1234abcd;
      for (int i = 0; i < 2000; i++) begin
        logic [31:0] x, y;
        st = st * 32'd1664525 + 32'd1013904223; x = st;
        st = st * 32'd1664525 + 32'd1013904223; y = st;
        run32("R1 random N32", x, y, st[7], 33'(x) + 33'(y) + 33'(st[7]));
      end
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(200000 * CLK_PERIOD);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule